// File: doc/BRIEF.md
# Memory Wait-State Cycle Calculator

This block tells a memory access engine how many bus cycles one access will occupy. The engine presents an address, a flag for word versus sub-word width and a sequential flag. The block answers one cycle later with the total cycle count, which includes the base access cycle. It then raises `busy` for the remaining cycles of that access.

Timing depends on the address region, taken from address bits [27:24]. Three ROM windows and a save-RAM window take their timing from a 16-bit control register. Software loads that register one byte at a time. Bit 14 of the register is a prefetch enable, which the block only stores and drives out.

The control flow is a two-state machine. IDLE accepts a request. It moves to BUSY (transition "launch") when the computed count is greater than 1, and otherwise stays in IDLE (transition "single"). BUSY counts down the remaining cycles. It returns to IDLE (transition "drain") when one cycle is left, and otherwise stays in BUSY (transition "hold"). Requests presented while in BUSY are dropped.

Top module: `ws_calc`

## Requirements
- R1: Only when address bits [31:28] are zero does the region decode apply. Region 2 costs 3 cycles for a sub-word access and 6 for a word. Regions 5 and 6 cost 1 cycle for a sub-word access and 2 for a word. Every other region outside 8 to F costs 1 cycle.
- R2: The first-access count of a ROM window is decoded from a 2-bit field: value 0 gives 5, 1 gives 4, 2 gives 3 and 3 gives 9. The fields sit at control bits [3:2] for regions 8-9, [6:5] for regions A-B and [9:8] for regions C-D.
- R3: The sequential count of a ROM window is 2 when its select bit is 1. When the select bit is 0 it is 3 for regions 8-9 (bit 4), 5 for regions A-B (bit 7) and 9 for regions C-D (bit 10).
- R4: A ROM access costs the sequential count when it is sequential and the first-access count otherwise. A word access adds one more sequential count.
- R5: A ROM access whose address bits [16:0] are all zero uses the first-access count even when the sequential flag is 1.
- R6: Regions E and F cost the first-access decode of control bits [1:0], whatever the width and sequential flags are.
- R7: Control bit 15 always reads 0, even after a write of 1. Control bit 14 drives `prefetch_en`.
- R8: Reset sets the control register to 0x0000. A write to the low byte (`cfg_wr_lo`) or the high byte (`cfg_wr_hi`) changes the timing of every access presented after the write edge.
- R9: When a request is accepted, `resp_valid` is 1 for one cycle with the count on `cycles_out`. `busy` is then high for exactly count-1 cycles, starting in that same cycle.
- R10: A request presented while `busy` is high is ignored. It produces no `resp_valid`, and `cycles_out` keeps its previous value.
- R11: An address with any of bits [31:28] set costs 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_lo | input | 1 | Write `cfg_wdata` into control bits [7:0] |
| cfg_wr_hi | input | 1 | Write `cfg_wdata` into control bits [15:8]; bit 15 is forced to 0 |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 16 | Current control register value |
| prefetch_en | output | 1 | Control bit 14 |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Access address |
| req_word | input | 1 | 1 for a word access, 0 for a byte or halfword access |
| req_seq | input | 1 | 1 for a sequential access |
| resp_valid | output | 1 | One-cycle strobe; `cycles_out` is valid |
| cycles_out | output | 5 | Total cycles of the last accepted access |
| busy | output | 1 | High for count-1 cycles after acceptance |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 5-bit count and a 17-bit boundary field. With these values the largest count, 18, fits in the counter, and the 128 KiB boundary can be reached with ordinary addresses. The bench steps the control register through several byte patterns so that every field of the 2-bit first-access table and both settings of every sequential bit get exercised. It also drives a request in the middle of a busy stretch and checks that the request is dropped.

// File: rtl/ws_pkg.sv
package ws_pkg;
    localparam int CNT_W  = 5;
    localparam int CTRL_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t first;
        cnt_t seq;
    } win_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } ws_state_e;

    function automatic cnt_t first_cycles(input logic [1:0] fld);
        cnt_t r;
        unique case (fld)
            2'd0: r = cnt_t'(5);
            2'd1: r = cnt_t'(4);
            2'd2: r = cnt_t'(3);
            default: r = cnt_t'(9);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ws_ctrl_reg.sv
module ws_ctrl_reg
    import ws_pkg::*;
#(
    parameter int NWIN = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_lo,
    input  logic                   wr_hi,
    input  logic [7:0]             wdata,
    output logic [CTRL_W-1:0]      ctrl_q,
    output win_t [NWIN-1:0]        wins,
    output cnt_t                   sram_first,
    output logic                   prefetch_en
);
    localparam int HALF = CTRL_W / 2;

    function automatic int fld_lsb(input int i);
        return (i == 0) ? 2 : (i == 1) ? 5 : 8;
    endfunction
    function automatic int seq_bit(input int i);
        return (i == 0) ? 4 : (i == 1) ? 7 : 10;
    endfunction
    function automatic int slow_seq(input int i);
        return (i == 0) ? 3 : (i == 1) ? 5 : 9;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_lo) ctrl_q[HALF-1:0]      <= wdata;
            if (wr_hi) ctrl_q[CTRL_W-1:HALF] <= {1'b0, wdata[HALF-2:0]};
        end
    end

    genvar g;
    generate
        for (g = 0; g < NWIN; g++) begin : g_win
            assign wins[g].first = first_cycles(ctrl_q[fld_lsb(g) +: 2]);
            assign wins[g].seq   = ctrl_q[seq_bit(g)] ? cnt_t'(2) : cnt_t'(slow_seq(g));
        end
    endgenerate

    assign sram_first  = first_cycles(ctrl_q[1:0]);
    assign prefetch_en = ctrl_q[14];

    // R7
    top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CTRL_W-1] == 1'b0);
endmodule

// File: rtl/ws_cycle_lut.sv
module ws_cycle_lut
    import ws_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BOUND_BITS = 17,
    parameter int NWIN       = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              word,
    input  logic              seq,
    input  win_t [NWIN-1:0]   wins,
    input  cnt_t              sram_first,
    output cnt_t              count
);
    logic [3:0] region;
    logic       hi_zero;
    logic       at_bound;
    logic       seq_eff;
    logic [1:0] win_idx;
    win_t       sel;

    assign region   = addr[27:24];
    assign hi_zero  = (addr[ADDR_W-1:28] == '0);
    assign at_bound = (addr[BOUND_BITS-1:0] == '0);
    assign seq_eff  = seq && !at_bound;
    assign win_idx  = (region[2:1] == 2'b11) ? 2'b00 : region[2:1];
    assign sel      = wins[win_idx];

    always_comb begin
        count = cnt_t'(1);
        if (hi_zero) begin
            unique case (region)
                4'h2:       count = word ? cnt_t'(6) : cnt_t'(3);
                4'h5, 4'h6: count = word ? cnt_t'(2) : cnt_t'(1);
                4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD:
                    count = (seq_eff ? sel.seq : sel.first) + (word ? sel.seq : cnt_t'(0));
                4'hE, 4'hF: count = sram_first;
                default:    count = cnt_t'(1);
            endcase
        end
    end
endmodule

// File: rtl/ws_busy_fsm.sv
module ws_busy_fsm
    import ws_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  cnt_t count,
    output logic resp_valid,
    output cnt_t cycles_q,
    output logic busy
);
    ws_state_e state_q, state_d;
    cnt_t      rem_q, rem_d;
    logic      accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && count > cnt_t'(1)) begin
                    state_d = ST_BUSY;
                    rem_d   = count - cnt_t'(1);
                end
            end
            ST_BUSY: begin
                if (rem_q == cnt_t'(1)) begin
                    state_d = ST_IDLE;
                    rem_d   = '0;
                end else begin
                    rem_d = rem_q - cnt_t'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            cycles_q   <= '0;
        end else begin
            resp_valid <= accept;
            if (accept) cycles_q <= count;
        end
    end

    assign busy = (state_q == ST_BUSY);

    // R9
    busy_follows_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && cycles_q > cnt_t'(1)) |-> busy);
    // R9
    no_busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && cycles_q == cnt_t'(1)) |-> !busy);
    // R9
    drain_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rem_q == cnt_t'(1)) |=> !busy);
    // R10
    busy_blocks_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !resp_valid);
endmodule

// File: rtl/ws_calc.sv
module ws_calc
    import ws_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BOUND_BITS = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_lo,
    input  logic              cfg_wr_hi,
    input  logic [7:0]        cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    output logic              prefetch_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic              req_seq,
    output logic              resp_valid,
    output logic [CNT_W-1:0]  cycles_out,
    output logic              busy
);
    localparam int NWIN = 3;

    win_t [NWIN-1:0] wins;
    cnt_t            sram_first;
    cnt_t            lut_count;

    ws_ctrl_reg #(.NWIN(NWIN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lo      (cfg_wr_lo),
        .wr_hi      (cfg_wr_hi),
        .wdata      (cfg_wdata),
        .ctrl_q     (cfg_rdata),
        .wins       (wins),
        .sram_first (sram_first),
        .prefetch_en(prefetch_en)
    );

    ws_cycle_lut #(.ADDR_W(ADDR_W), .BOUND_BITS(BOUND_BITS), .NWIN(NWIN)) u_lut (
        .addr      (req_addr),
        .word      (req_word),
        .seq       (req_seq),
        .wins      (wins),
        .sram_first(sram_first),
        .count     (lut_count)
    );

    ws_busy_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .count     (lut_count),
        .resp_valid(resp_valid),
        .cycles_q  (cycles_out),
        .busy      (busy)
    );

    // R11
    high_addr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[ADDR_W-1:28] != '0) |-> lut_count == cnt_t'(1));
    // R1
    slow_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[ADDR_W-1:24] == 'h02) |->
        (lut_count == cnt_t'(3) || lut_count == cnt_t'(6)));
    // R6
    save_ram_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[ADDR_W-1:25] == 'h7) |->
        (lut_count == cnt_t'(3) || lut_count == cnt_t'(4) ||
         lut_count == cnt_t'(5) || lut_count == cnt_t'(9)));
endmodule

// File: tb/ws_calc_test.sv
module ws_calc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_lo = 1'b0, cfg_wr_hi = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        prefetch_en;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_word = 1'b0, req_seq = 1'b0;
    logic        resp_valid;
    logic [4:0]  cycles_out;
    logic        busy;

    int checks = 0;
    int failures = 0;
    logic [15:0] shadow = '0;
    int exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    ws_calc uut (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int first_of(input logic [1:0] f);
        case (f)
            2'd0: return 5;
            2'd1: return 4;
            2'd2: return 3;
            default: return 9;
        endcase
    endfunction

    function automatic int model(input logic [15:0] c, input logic [31:0] a,
                                 input logic w, input logic s);
        int fa, sq;
        logic se;
        if (a[31:28] != 0) return 1;
        se = s && (a[16:0] != 0);
        case (a[27:24])
            4'h2: return w ? 6 : 3;
            4'h5, 4'h6: return w ? 2 : 1;
            4'h8, 4'h9: begin fa = first_of(c[3:2]); sq = c[4] ? 2 : 3; end
            4'hA, 4'hB: begin fa = first_of(c[6:5]); sq = c[7] ? 2 : 5; end
            4'hC, 4'hD: begin fa = first_of(c[9:8]); sq = c[10] ? 2 : 9; end
            4'hE, 4'hF: return first_of(c[1:0]);
            default: return 1;
        endcase
        return (se ? sq : fa) + (w ? sq : 0);
    endfunction

    // Monitor: pops expected counts and measures the busy stretch
    initial begin
        forever begin
            @(negedge clk);
            if (resp_valid) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected response", 1, 0);
                end else begin
                    int e, n;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, int'(cycles_out), e);
                    n = 0;
                    while (busy) begin
                        n++;
                        @(negedge clk);
                    end
                    check({"R9 busy length ", t}, n, e - 1);
                end
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic access(input string tag, input logic [31:0] a,
                          input logic w, input logic s, input logic poke = 1'b0);
        int e;
        e = model(shadow, a, w, s);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_word = w; req_seq = s;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            // R10: request while busy must be dropped
            req_valid = 1'b1; req_addr = 32'h0300_0000; req_word = 1'b0; req_seq = 1'b0;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait_idle();
        if (poke) check("R10 cycles_out kept", int'(cycles_out), e);
    endtask

    task automatic wr(input logic hi, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_lo = !hi; cfg_wr_hi = hi; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_lo = 1'b0; cfg_wr_hi = 1'b0;
        if (hi) shadow[15:8] = {1'b0, d[6:0]};
        else    shadow[7:0]  = d;
    endtask

    initial begin
        #(4 * 200000);
        check("watchdog expired", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset ctrl", int'(cfg_rdata), 0);
        check("R8 reset cycles_out", int'(cycles_out), 0);
        check("R9 reset busy", int'(busy), 0);
        check("R7 reset prefetch", int'(prefetch_en), 0);

        access("R5 R8 boundary forces first", 32'h0800_0000, 1'b0, 1'b1);
        access("R3 w0 slow seq", 32'h0800_0004, 1'b0, 1'b1);
        access("R4 w0 word seq", 32'h0800_0004, 1'b1, 1'b1);
        access("R4 w1 word seq", 32'h0A00_0010, 1'b1, 1'b1);
        access("R2 R4 w2 word first", 32'h0C00_0010, 1'b1, 1'b0);
        access("R1 slow ram sub", 32'h0200_0000, 1'b0, 1'b0);
        access("R1 slow ram word", 32'h0200_0100, 1'b1, 1'b1);
        access("R1 palette sub", 32'h0500_0000, 1'b0, 1'b0);
        access("R1 video word", 32'h0600_0040, 1'b1, 1'b0);
        access("R1 fast ram", 32'h0300_0000, 1'b1, 1'b0);
        access("R1 io region", 32'h0400_0000, 1'b1, 1'b1);
        access("R6 save ram word seq", 32'h0E00_0010, 1'b1, 1'b1);
        access("R11 high address", 32'h1800_0000, 1'b1, 1'b0);

        wr(1'b0, 8'hFF);
        check("R8 low write readback", int'(cfg_rdata), 16'h00FF);
        access("R6 R2 save ram field 3", 32'h0E00_0000, 1'b0, 1'b0);
        access("R2 w0 field 3", 32'h0800_0100, 1'b0, 1'b0);
        access("R3 R4 w0 fast seq word", 32'h0800_0100, 1'b1, 1'b1);
        access("R5 w1 boundary", 32'h0A02_0000, 1'b0, 1'b1);

        wr(1'b1, 8'hFF);
        check("R7 bit15 reads 0", int'(cfg_rdata), 16'h7FFF);
        check("R7 prefetch set", int'(prefetch_en), 1);
        access("R3 R4 w2 fast seq word", 32'h0C00_0002, 1'b1, 1'b1);
        access("R2 w2 field 3", 32'h0D00_0002, 1'b0, 1'b0);

        wr(1'b0, 8'h5A);
        access("R6 save field 2", 32'h0F00_0004, 1'b1, 1'b1);
        access("R2 R3 w1 field 2 word", 32'h0A00_0020, 1'b1, 1'b0);
        access("R2 w0 field 2", 32'h0900_0020, 1'b0, 1'b0);

        wr(1'b1, 8'h00);
        check("R7 prefetch clear", int'(prefetch_en), 0);
        check("R8 readback", int'(cfg_rdata), 16'h005A);
        access("R3 w2 slow seq", 32'h0C00_0004, 1'b0, 1'b1);
        access("R10 drop during busy", 32'h0800_0200, 1'b0, 1'b0, 1'b1);

        wr(1'b1, 8'h03);
        access("R2 R4 w2 max count", 32'h0C00_0004, 1'b1, 1'b0);
        access("R9 single cycle", 32'h0000_0000, 1'b0, 1'b0);

        repeat (4) @(negedge clk);
        check("R9 queue drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule